// File: doc/BRIEF.md
# Bus Cycle Watchdog Timer

This block guards a local bus against accesses that never finish. Software loads an 8-bit limit into a read/write register. Each bus access is timed in clocks of the 25 MHz time base, so one count is 40 ns. When an access is still open after the programmed number of counts, the block ends it with a one-clock terminate pulse and latches a bus-error interrupt flag. While that flag stays set, it drives two status LEDs in a matched slow blink.

A limit of zero switches the guard off. Any value from 1 to 255 arms it, which covers 40 ns up to about 10.2 us. The limit is captured when an access opens, so a rewrite made during an access applies only to the next one. The interrupt flag stays set until it is cleared through a dedicated clear input. Clearing it also stops the LED blink.

Top module: `bus_cycle_guard`

## Requirements
- R1: After reset, `cfg_rdata` is 0x00, and `force_term`, `irq_flag`, `led_a` and `led_b` are all low.
- R2: A clock with `cfg_we` high loads `cfg_wdata` into the limit register. `cfg_rdata` shows the new value from the next clock on.
- R3: With a captured limit of 0x00, no access is ever terminated and `irq_flag` never rises, however long the access lasts.
- R4: Let the captured limit be L (1 to 255), and let the first clock that samples `cyc_active` high with `cyc_done` low count as clock 1. If the access neither ends nor completes, `force_term` is high for exactly one clock: the one after clock L+1.
- R5: A clock that samples `cyc_done` high, or `cyc_active` low, ends the access and clears the count. A following access is timed from zero again.
- R6: The limit is captured on the first clock of an access. A register write made during an access does not change that access's timeout, but it is used by the next access.
- R7: `irq_flag` rises on the clock after a `force_term` pulse. It stays high until a clock samples `irq_clr` high. When a terminate and a clear meet on the same clock, the set takes priority.
- R8: While `irq_flag` is high, `led_a` and `led_b` are equal. Starting one clock after the flag rises, they are high for BLINK_HALF clocks, then low for BLINK_HALF clocks, and the pattern repeats. Both LEDs go low one clock after the flag clears and stay low while it is clear.
- R9: An access that has been terminated produces no further `force_term` pulse until it ends and a new access opens.
- R10: The largest limit, 255, terminates an access after 256 clocks, as R4 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz time base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wdata | input | 8 | Limit register write data |
| cfg_we | input | 1 | Limit register write enable |
| cfg_rdata | output | 8 | Limit register readback |
| cyc_active | input | 1 | A bus access is in progress |
| cyc_done | input | 1 | The current access completes this clock |
| force_term | output | 1 | One-clock pulse that forces the access to end |
| irq_flag | output | 1 | Sticky bus-error interrupt |
| irq_clr | input | 1 | Clears the interrupt flag |
| led_a | output | 1 | Status LED drive, fault blink |
| led_b | output | 1 | Status LED drive, fault blink |

## Verification
The bench builds the block with BLINK_HALF set to 4, in place of the default of one million clocks. This keeps several full on/off LED phases within a few dozen clocks, so the blink timing, the match between the two LEDs and the stop on clear can all be checked clock by clock. The limit width stays at its default of 8 bits. This lets the bench reach the real end of the range, a limit of 255, with the full access timed, and also cover the disable value zero and the smallest limit, one.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // number of status LED drives fed by the blinker
  localparam int unsigned LED_COUNT = 2;

  // access tracking state of the cycle timer
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_RUN   = 2'd1,
    ACC_SPENT = 2'd2
  } acc_state_e;
endpackage

// File: rtl/bcg_rst_sync.sv
module bcg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bcg_limit_reg.sv
module bcg_limit_reg #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LIM_W-1:0] wr_data,
  output logic [LIM_W-1:0] limit_q
);
  logic [LIM_W-1:0] limit_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_r <= '0;
    end else if (wr_en) begin
      limit_r <= wr_data;
    end
  end

  assign limit_q = limit_r;
endmodule

// File: rtl/bcg_cycle_timer.sv
module bcg_cycle_timer
  import bcg_pkg::*;
#(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             cyc_active,
  input  logic             cyc_done,
  output logic             term_o,
  output logic [LIM_W-1:0] lim_cur_o
);
  acc_state_e       state_q, state_n;
  logic [LIM_W-1:0] cnt_q, cnt_n;
  logic [LIM_W-1:0] lim_q, lim_n;
  logic             term_q, term_n;
  logic             acc_end;
  logic             armed;

  assign acc_end = cyc_done | ~cyc_active;
  assign armed   = (lim_q != '0);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    lim_n   = lim_q;
    term_n  = 1'b0;
    unique case (state_q)
      ACC_IDLE: begin
        if (!acc_end) begin
          state_n = ACC_RUN;
          cnt_n   = LIM_W'(1);
          lim_n   = limit_i;
        end
      end
      ACC_RUN: begin
        if (acc_end) begin
          state_n = ACC_IDLE;
          cnt_n   = '0;
        end else if (armed) begin
          if (cnt_q == lim_q) begin
            term_n  = 1'b1;
            state_n = ACC_SPENT;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ACC_SPENT: begin
        if (acc_end) begin
          state_n = ACC_IDLE;
          cnt_n   = '0;
        end
      end
      default: begin
        state_n = ACC_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACC_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
      term_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      lim_q   <= lim_n;
      term_q  <= term_n;
    end
  end

  assign term_o    = term_q;
  assign lim_cur_o = lim_q;
endmodule

// File: rtl/bcg_fault_blink.sv
module bcg_fault_blink #(
  parameter int unsigned HALF  = 1000000,
  parameter int unsigned N_LED = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_i,
  output logic [N_LED-1:0] led_o
);
  localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);

  logic [DIV_W-1:0] div_q, div_n;
  logic             ph_q, ph_n;
  logic             lit_n;

  // idle preset makes the first fault clock wrap into the lit phase
  always_comb begin
    if (!fault_i) begin
      div_n = DIV_LAST;
      ph_n  = 1'b1;
    end else if (div_q == DIV_LAST) begin
      div_n = '0;
      ph_n  = ~ph_q;
    end else begin
      div_n = div_q + 1'b1;
      ph_n  = ph_q;
    end
    lit_n = fault_i & ~ph_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_LAST;
      ph_q  <= 1'b1;
    end else begin
      div_q <= div_n;
      ph_q  <= ph_n;
    end
  end

  for (genvar g = 0; g < N_LED; g++) begin : g_led
    logic led_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        led_q <= 1'b0;
      end else begin
        led_q <= lit_n;
      end
    end
    assign led_o[g] = led_q;
  end
endmodule

// File: rtl/bus_cycle_guard.sv
module bus_cycle_guard
  import bcg_pkg::*;
#(
  parameter int unsigned LIM_W      = 8,
  parameter int unsigned BLINK_HALF = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] cfg_wdata,
  input  logic             cfg_we,
  output logic [LIM_W-1:0] cfg_rdata,
  input  logic             cyc_active,
  input  logic             cyc_done,
  output logic             force_term,
  output logic             irq_flag,
  input  logic             irq_clr,
  output logic             led_a,
  output logic             led_b
);
  logic                 rst_sync_n;
  logic [LIM_W-1:0]     limit_q;
  logic [LIM_W-1:0]     cur_lim;
  logic                 term;
  logic                 irq_q, irq_n;
  logic [LED_COUNT-1:0] leds;

  bcg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bcg_limit_reg #(.LIM_W(LIM_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .limit_q (limit_q)
  );

  bcg_cycle_timer #(.LIM_W(LIM_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .limit_i    (limit_q),
    .cyc_active (cyc_active),
    .cyc_done   (cyc_done),
    .term_o     (term),
    .lim_cur_o  (cur_lim)
  );

  // set has priority over a clear on the same clock
  always_comb begin
    irq_n = term | (irq_q & ~irq_clr);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_n;
    end
  end

  bcg_fault_blink #(.HALF(BLINK_HALF), .N_LED(LED_COUNT)) u_blink (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fault_i (irq_q),
    .led_o   (leds)
  );

  assign cfg_rdata  = limit_q;
  assign force_term = term;
  assign irq_flag   = irq_q;
  assign led_a      = leds[0];
  assign led_b      = leds[1];
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
  parameter int unsigned LIM_W = 8
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             cfg_we,
  input logic [LIM_W-1:0] cfg_wdata,
  input logic [LIM_W-1:0] cfg_rdata,
  input logic             force_term,
  input logic             irq_flag,
  input logic             irq_clr,
  input logic             led_a,
  input logic             led_b,
  input logic [LIM_W-1:0] lim_cur
);
  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  // R3
  zero_limit_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    force_term |-> lim_cur != '0);

  // R9
  term_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    force_term |=> !force_term);

  // R7
  irq_follows_term_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    force_term |=> irq_flag);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R8
  led_pair_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    led_a == led_b);

  // R8
  led_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !irq_flag |=> !led_a);
endmodule

bind bus_cycle_guard bcg_chk #(.LIM_W(LIM_W)) chk_i (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .force_term (force_term),
  .irq_flag   (irq_flag),
  .irq_clr    (irq_clr),
  .led_a      (led_a),
  .led_b      (led_b),
  .lim_cur    (cur_lim)
);

// File: tb/bus_cycle_guard_tb_top.sv
module bus_cycle_guard_tb_top;
  localparam int CLK_PERIOD = 40;
  localparam int HALF       = 4;

  logic       clk;
  logic       rst_n;
  logic [7:0] cfg_wdata;
  logic       cfg_we;
  logic [7:0] cfg_rdata;
  logic       cyc_active;
  logic       cyc_done;
  logic       force_term;
  logic       irq_flag;
  logic       irq_clr;
  logic       led_a;
  logic       led_b;

  int tests;
  int fails;

  bus_cycle_guard #(.LIM_W(8), .BLINK_HALF(HALF)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wdata  (cfg_wdata),
    .cfg_we     (cfg_we),
    .cfg_rdata  (cfg_rdata),
    .cyc_active (cyc_active),
    .cyc_done   (cyc_done),
    .force_term (force_term),
    .irq_flag   (irq_flag),
    .irq_clr    (irq_clr),
    .led_a      (led_a),
    .led_b      (led_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_limit(input int v);
    cfg_wdata = 8'(v);
    cfg_we    = 1'b1;
    tick();
    cfg_we    = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    tick();
    irq_clr = 1'b0;
    tick();
  endtask

  // R1
  task automatic t_reset();
    chk("R1 rdata", int'(cfg_rdata), 0);
    chk("R1 force", int'(force_term), 0);
    chk("R1 irq", int'(irq_flag), 0);
    chk("R1 leds", int'({led_a, led_b}), 0);
  endtask

  // R2
  task automatic t_readback();
    write_limit(8'hA5);
    chk("R2 readback A5", int'(cfg_rdata), 8'hA5);
    write_limit(8'h3C);
    chk("R2 readback 3C", int'(cfg_rdata), 8'h3C);
  endtask

  // R3
  task automatic t_disabled();
    int bad;
    bad = 0;
    write_limit(0);
    cyc_active = 1'b1;
    for (int n = 1; n <= 300; n++) begin
      tick();
      if (force_term || irq_flag) bad++;
    end
    cyc_active = 1'b0;
    tick();
    chk("R3 no terminate when limit zero", bad, 0);
    chk("R3 irq stays low", int'(irq_flag), 0);
  endtask

  // R4 R7 R8 R9 R10: full timeout, LED blink and clear
  task automatic t_timeout(input int lim, input string tag);
    int fbad, ibad, lbad, pbad, j, exp_led;
    fbad = 0; ibad = 0; lbad = 0; pbad = 0;
    write_limit(lim);
    cyc_active = 1'b1;
    for (int n = 1; n <= lim + 2 + 3 * HALF; n++) begin
      tick();
      if (int'(force_term) != ((n == lim + 1) ? 1 : 0)) fbad++;
      if (int'(irq_flag) != ((n >= lim + 2) ? 1 : 0)) ibad++;
      j = n - (lim + 2);
      exp_led = (j >= 1 && (((j - 1) / HALF) % 2) == 0) ? 1 : 0;
      if (int'(led_a) != exp_led) lbad++;
      if (led_a !== led_b) pbad++;
    end
    chk({tag, " R4 force_term single pulse at L+1 (R9 no repeat)"}, fbad, 0);
    chk({tag, " R7 irq set after terminate and held"}, ibad, 0);
    chk({tag, " R8 led blink phases"}, lbad, 0);
    chk({tag, " R8 leds identical"}, pbad, 0);
    cyc_active = 1'b0;
    tick();
    chk({tag, " R7 irq held after access ends"}, int'(irq_flag), 1);
    clear_irq();
    chk({tag, " R7 irq cleared"}, int'(irq_flag), 0);
    chk({tag, " R8 leds off after clear"}, int'({led_a, led_b}), 0);
    repeat (2 * HALF) tick();
    chk({tag, " R8 leds stay off"}, int'({led_a, led_b}), 0);
  endtask

  // R5
  task automatic t_done_early();
    int bad;
    bad = 0;
    write_limit(5);
    cyc_active = 1'b1;
    for (int n = 1; n <= 4; n++) begin
      tick();
      if (force_term) bad++;
    end
    cyc_done = 1'b1;
    tick();
    if (force_term) bad++;
    cyc_done = 1'b0;
    for (int n = 1; n <= 5; n++) begin
      tick();
      if (force_term) bad++;
    end
    cyc_active = 1'b0;
    tick();
    if (force_term) bad++;
    chk("R5 done before limit restarts count", bad, 0);
    chk("R5 no irq", int'(irq_flag), 0);
  endtask

  // R6
  task automatic t_rewrite();
    int bad;
    bad = 0;
    write_limit(10);
    cyc_active = 1'b1;
    for (int n = 1; n <= 14; n++) begin
      if (n == 3) begin
        cfg_wdata = 8'd3;
        cfg_we    = 1'b1;
      end else begin
        cfg_we = 1'b0;
      end
      tick();
      if (int'(force_term) != ((n == 11) ? 1 : 0)) bad++;
    end
    cfg_we = 1'b0;
    chk("R6 old limit kept for current access", bad, 0);
    chk("R6 register holds new value", int'(cfg_rdata), 3);
    cyc_active = 1'b0;
    tick();
    clear_irq();
    bad = 0;
    cyc_active = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      tick();
      if (int'(force_term) != ((n == 4) ? 1 : 0)) bad++;
    end
    cyc_active = 1'b0;
    tick();
    chk("R6 new limit used by next access", bad, 0);
    clear_irq();
  endtask

  // R7 set priority over clear
  task automatic t_set_wins();
    write_limit(2);
    irq_clr    = 1'b1;
    cyc_active = 1'b1;
    repeat (4) tick();
    chk("R7 set wins over clear", int'(irq_flag), 1);
    tick();
    chk("R7 clear applies next clock", int'(irq_flag), 0);
    irq_clr    = 1'b0;
    cyc_active = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0;
    fails = 0;
    rst_n = 1'b0;
    cfg_wdata = '0;
    cfg_we = 1'b0;
    cyc_active = 1'b0;
    cyc_done = 1'b0;
    irq_clr = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_readback();
    t_disabled();
    t_timeout(1, "L1");
    t_timeout(7, "L7");
    t_timeout(255, "R10 L255");
    t_done_early();
    t_rewrite();
    t_set_wins();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule